// File: doc/BRIEF.md
# Trap Condition Compare Unit

This block decides whether a conditional trap instruction should be taken. It takes two operands and a five-bit condition mask. It checks the operands against each other as signed numbers and as unsigned numbers in the same cycle. If any relation selected by the mask is true, it raises a trap request.

A mode input chooses the operand width. In word mode only the low 32 bits of each operand take part, read as 32-bit signed or unsigned values. In doubleword mode all 64 bits are compared.

The decision is registered. It appears one clock after the input strobe, together with a one-cycle valid pulse. When a trap is taken, the block also reports a fixed program-exception subcode that identifies the exception as a trap. Instruction decode and exception dispatch are handled elsewhere.

Top module: `trap_cmp_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid`, `trap_hit` and `trap_code` are all zero after that edge, whatever the other inputs are.
- R2: `out_valid` is high in the cycle after a rising edge at which `in_valid` was high, and low in the cycle after a rising edge at which `in_valid` was low. A cycle with `in_valid` low never produces `trap_hit`.
- R3: Mask bit 4 (value 0x10) requests a trap when A is less than B as signed numbers.
- R4: Mask bit 3 (value 0x08) requests a trap when A is greater than B as signed numbers.
- R5: Mask bit 2 (value 0x04) requests a trap when A equals B.
- R6: Mask bit 1 (value 0x02) requests a trap when A is less than B as unsigned numbers. Mask bit 0 (value 0x01) requests a trap when A is greater than B as unsigned numbers.
- R7: `trap_hit` is the logical OR of every enabled condition that holds. Of the three signed relations (less, greater, equal), exactly one holds for any operand pair.
- R8: When `dword_mode` is 0 (word mode), only bits 31:0 of each operand are compared, as 32-bit signed or unsigned values. Bits 63:32 have no effect.
- R9: When `dword_mode` is 1 (doubleword mode), all 64 bits are compared, with bit 63 as the sign.
- R10: A mask of 0x00 never traps. A mask of 0x1F always traps on a valid cycle.
- R11: `trap_code` equals 4'h4 (the trap subcode) in any cycle where `trap_hit` is high, and 4'h0 otherwise. `trap_hit` is low whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe that marks a compare request |
| dword_mode | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare on the low halves |
| opnd_a | input | 64 | First operand (A) |
| opnd_b | input | 64 | Second operand (B) |
| cond_mask | input | 5 | Condition select: bit4 signed less, bit3 signed greater, bit2 equal, bit1 unsigned less, bit0 unsigned greater |
| out_valid | output | 1 | One-cycle pulse one clock after `in_valid` |
| trap_hit | output | 1 | Trap request, valid together with `out_valid` |
| trap_code | output | 4 | Program-exception subcode, 4'h4 when trapping and 0 otherwise |

## Verification
The hardest case to reach is word mode with operands whose upper halves disagree with their lower halves. For example, the low halves may be equal while the full values differ, or bit 31 may carry the opposite sign from bit 63. Random 64-bit operands almost never give equal low words, and they rarely show the effect clearly.

The stimulus therefore builds these pairs on purpose:
- It fixes the low halves (equal, sign-flipped at bit 31, or all ones against one) and fills the upper halves with unrelated values.
- It runs the same pair in both modes, so the two decisions can be compared against each other.
- Its random phase often copies A into B, or copies only A's low half into B.

// File: rtl/trap_cmp_pkg.sv
// Package: shared constants for the trap condition compare unit.
// Assumes a five-entry condition vector whose bit order matches the mask
// bit order: each mask bit enables the relation at the same index.
package trap_cmp_pkg;

    localparam int COND_W   = 5;
    localparam int IDX_LT_S = 4;   // signed less-than
    localparam int IDX_GT_S = 3;   // signed greater-than
    localparam int IDX_EQ   = 2;   // equality
    localparam int IDX_LT_U = 1;   // unsigned less-than
    localparam int IDX_GT_U = 0;   // unsigned greater-than

    typedef logic [COND_W-1:0] cond_vec_t;

endpackage

// File: rtl/trap_operand_sel.sv
// Module: trap_operand_sel
// Narrows the operands to the active width. In word mode the low WORD_W bits
// are zero-extended, so one unsigned comparator serves both modes. The sign
// bit of each operand is taken from the top of the active width.
// Assumes DATA_W > WORD_W.
module trap_operand_sel #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic              dword_mode,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] a_ext,
    output logic [DATA_W-1:0] b_ext,
    output logic              a_neg,
    output logic              b_neg
);
    localparam int PAD_W = DATA_W - WORD_W;

    // Pick full or zero-extended low-half operands and their sign bits.
    always_comb begin
        if (dword_mode) begin
            a_ext = a_in;
            b_ext = b_in;
            a_neg = a_in[DATA_W-1];
            b_neg = b_in[DATA_W-1];
        end else begin
            a_ext = {{PAD_W{1'b0}}, a_in[WORD_W-1:0]};
            b_ext = {{PAD_W{1'b0}}, b_in[WORD_W-1:0]};
            a_neg = a_in[WORD_W-1];
            b_neg = b_in[WORD_W-1];
        end
    end
endmodule

// File: rtl/trap_rel_cmp.sv
// Module: trap_rel_cmp
// Produces all five relations from one unsigned magnitude comparator.
// Signed order follows the unsigned order when the signs match. When the
// signs differ, the negative operand is the smaller one.
// Assumes the operands are already narrowed (see trap_operand_sel).
module trap_rel_cmp
    import trap_cmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_ext,
    input  logic [DATA_W-1:0] b_ext,
    input  logic              a_neg,
    input  logic              b_neg,
    output cond_vec_t         rel
);
    logic lt_u;
    logic eq;
    logic sign_diff;

    // Shared magnitude compare and equality.
    always_comb begin
        lt_u      = (a_ext < b_ext);
        eq        = (a_ext == b_ext);
        sign_diff = a_neg ^ b_neg;
    end

    // Assemble the relation vector in mask bit order.
    always_comb begin
        rel           = '0;
        rel[IDX_EQ]   = eq;
        rel[IDX_LT_U] = lt_u;
        rel[IDX_GT_U] = !lt_u && !eq;
        rel[IDX_LT_S] = sign_diff ? a_neg : lt_u;
        rel[IDX_GT_S] = sign_diff ? b_neg : (!lt_u && !eq);
    end
endmodule

// File: rtl/trap_cond_reduce.sv
// Module: trap_cond_reduce
// Gates each relation with its mask bit and ORs the results into one
// trap request. Assumes rel and mask share the same bit order.
module trap_cond_reduce
    import trap_cmp_pkg::*;
(
    input  cond_vec_t rel,
    input  cond_vec_t mask,
    output logic      hit
);
    cond_vec_t gated;

    // One enable gate per condition.
    for (genvar i = 0; i < COND_W; i++) begin : g_gate
        assign gated[i] = rel[i] & mask[i];
    end

    // Any enabled relation that holds raises the request.
    always_comb begin
        hit = |gated;
    end
endmodule

// File: rtl/trap_cmp_unit.sv
// Module: trap_cmp_unit (top)
// Evaluates a conditional trap. Operands are narrowed to the active width,
// compared in signed and unsigned form, masked and reduced. The decision is
// registered and presented one clock later with a valid pulse and a trap
// subcode. Assumes in_valid is a single-cycle or back-to-back strobe. There
// is no backpressure. Reset is synchronous and active low.
module trap_cmp_unit
    import trap_cmp_pkg::*;
#(
    parameter int             DATA_W       = 64,
    parameter int             WORD_W       = 32,
    parameter int             CODE_W       = 4,
    parameter logic [CODE_W-1:0] TRAP_SUBCODE = 4'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dword_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [COND_W-1:0] cond_mask,
    output logic              out_valid,
    output logic              trap_hit,
    output logic [CODE_W-1:0] trap_code
);
    logic [DATA_W-1:0] a_ext;
    logic [DATA_W-1:0] b_ext;
    logic              a_neg;
    logic              b_neg;
    cond_vec_t         rel;
    logic              hit;
    logic              take;

    trap_operand_sel #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_sel (
        .dword_mode (dword_mode),
        .a_in       (opnd_a),
        .b_in       (opnd_b),
        .a_ext      (a_ext),
        .b_ext      (b_ext),
        .a_neg      (a_neg),
        .b_neg      (b_neg)
    );

    trap_rel_cmp #(.DATA_W(DATA_W)) u_cmp (
        .a_ext (a_ext),
        .b_ext (b_ext),
        .a_neg (a_neg),
        .b_neg (b_neg),
        .rel   (rel)
    );

    trap_cond_reduce u_red (
        .rel  (rel),
        .mask (cond_mask),
        .hit  (hit)
    );

    // A trap is only taken on a valid request.
    always_comb begin
        take = in_valid & hit;
    end

    // Result register: valid pulse, trap flag and subcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            trap_hit  <= 1'b0;
            trap_code <= '0;
        end else begin
            out_valid <= in_valid;
            trap_hit  <= take;
            trap_code <= take ? TRAP_SUBCODE : '0;
        end
    end

    // R2: the valid pulse follows the request strobe by one cycle.
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11: no trap flag without a valid pulse, and the subcode matches the flag.
    p_hit_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !trap_hit);
    p_code_on_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_hit |-> (trap_code == TRAP_SUBCODE));
    p_code_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_hit |-> (trap_code == '0));

    // R10: an empty mask never traps, and a full mask always traps.
    p_zero_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == '0) |=> !trap_hit);
    p_full_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == '1) |=> trap_hit);

    // R7: exactly one of the signed relations holds on a valid request.
    p_signed_trichotomy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ($countones({rel[IDX_LT_S], rel[IDX_GT_S], rel[IDX_EQ]}) == 1));

    // R8: in word mode, equal low halves count as equal regardless of the upper bits.
    p_word_eq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dword_mode && opnd_a[WORD_W-1:0] == opnd_b[WORD_W-1:0]) |-> rel[IDX_EQ]);

    // R6: the unsigned relations never hold together.
    p_unsigned_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $onehot0({rel[IDX_LT_U], rel[IDX_GT_U], rel[IDX_EQ]}));
endmodule

// File: tb/trap_cmp_unit_test.sv
// Bench for trap_cmp_unit. A behavioural reference built on native signed
// and unsigned longint compares predicts every cycle's outputs.
module trap_cmp_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dword_mode = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [4:0]  cond_mask = '0;
    logic        out_valid;
    logic        trap_hit;
    logic [3:0]  trap_code;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    bit    exp_valid = 0;
    bit    exp_hit = 0;
    string exp_tag = "R1";

    always #10 clk = ~clk;

    trap_cmp_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .dword_mode (dword_mode),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .cond_mask  (cond_mask),
        .out_valid  (out_valid),
        .trap_hit   (trap_hit),
        .trap_code  (trap_code)
    );

    // Reference decision from the requirements (R3..R10).
    function automatic bit ref_trap(bit dw, logic [63:0] a, logic [63:0] b, logic [4:0] m);
        longint          sa, sb;
        longint unsigned ua, ub;
        if (dw) begin
            sa = a; sb = b; ua = a; ub = b;
        end else begin
            sa = {{32{a[31]}}, a[31:0]};
            sb = {{32{b[31]}}, b[31:0]};
            ua = {32'b0, a[31:0]};
            ub = {32'b0, b[31:0]};
        end
        return (m[4] && sa < sb) || (m[3] && sa > sb) || (m[2] && ua == ub) ||
               (m[1] && ua < ub) || (m[0] && ua > ub);
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Check the previous cycle's prediction, then drive a new request.
    task automatic step(bit v, bit dw, logic [63:0] a, logic [63:0] b, logic [4:0] m, string tag);
        @(negedge clk);
        check("R2", "out_valid", {63'b0, out_valid}, {63'b0, exp_valid});
        check(exp_tag, "trap_hit", {63'b0, trap_hit}, {63'b0, exp_hit});
        check("R11", "trap_code", {60'b0, trap_code}, exp_hit ? 64'h4 : 64'h0);
        in_valid   = v;
        dword_mode = dw;
        opnd_a     = a;
        opnd_b     = b;
        cond_mask  = m;
        exp_valid  = v;
        exp_hit    = v && ref_trap(dw, a, b, m);
        exp_tag    = tag;
    endtask

    localparam logic [63:0] NEG5 = 64'hFFFF_FFFF_FFFF_FFFB;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    initial begin
        // R1: reset dominates a full-mask request.
        in_valid  = 1'b1;
        cond_mask = 5'h1F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "out_valid", {63'b0, out_valid}, 64'h0);
        check("R1", "trap_hit", {63'b0, trap_hit}, 64'h0);
        check("R1", "trap_code", {60'b0, trap_code}, 64'h0);
        rst_n    = 1'b1;
        in_valid = 1'b0;

        // R3 signed less
        step(1, 1, NEG5, 64'd3, 5'h10, "R3");
        step(1, 1, 64'd3, NEG5, 5'h10, "R3");
        // R4 signed greater
        step(1, 1, 64'd3, NEG5, 5'h08, "R4");
        step(1, 1, NEG5, 64'd3, 5'h08, "R4");
        // R5 equal
        step(1, 1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04, "R5");
        step(1, 1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1, 5'h04, "R5");
        // R6 unsigned less / greater
        step(1, 1, 64'd1, ONES, 5'h02, "R6");
        step(1, 1, ONES, 64'd1, 5'h01, "R6");
        step(1, 1, ONES, 64'd1, 5'h02, "R6");
        step(1, 1, 64'd1, ONES, 5'h01, "R6");
        // R7 OR of conditions
        step(1, 1, 64'd7, 64'd9, 5'h18, "R7");
        step(1, 1, 64'd9, 64'd9, 5'h18, "R7");
        step(1, 1, 64'd9, 64'd9, 5'h14, "R7");
        step(1, 1, NEG5, 64'd3, 5'h09, "R7");
        // R8 word mode ignores upper halves
        step(1, 0, 64'h0000_0001_0000_0000, 64'h0, 5'h04, "R8");
        step(1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 5'h10, "R8");
        step(1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 5'h01, "R8");
        step(1, 0, 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0009, 5'h02, "R8");
        step(1, 0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF, 5'h10, "R8");
        // R9 doubleword mode uses all bits
        step(1, 1, 64'h0000_0001_0000_0000, 64'h0, 5'h04, "R9");
        step(1, 1, 64'h0000_0001_0000_0000, 64'h0, 5'h08, "R9");
        step(1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 5'h10, "R9");
        step(1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 5'h08, "R9");
        step(1, 1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 5'h10, "R9");
        // R10 empty and full masks
        step(1, 1, NEG5, 64'd3, 5'h00, "R10");
        step(1, 0, 64'd4, 64'd4, 5'h00, "R10");
        step(1, 1, NEG5, 64'd3, 5'h1F, "R10");
        step(1, 0, 64'd4, 64'd4, 5'h1F, "R10");
        step(1, 1, 64'd0, ONES, 5'h1F, "R10");
        // R2 idle cycles with a full mask produce nothing
        step(0, 1, 64'd4, 64'd4, 5'h1F, "R2");
        step(0, 0, NEG5, 64'd3, 5'h1F, "R2");
        step(1, 1, 64'd4, 64'd4, 5'h04, "R2");
        step(0, 1, 64'd4, 64'd4, 5'h04, "R2");

        // Random phase: mixed modes, forced equal low halves and full copies.
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] a;
            logic [63:0] b;
            int          sel;
            a   = {$urandom, $urandom};
            b   = {$urandom, $urandom};
            sel = $urandom_range(0, 5);
            if (sel == 0) b = a;
            else if (sel == 1) b = {b[63:32], a[31:0]};
            else if (sel == 2) b = {a[63:32], b[31:0]};
            step(($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1, a, b,
                 5'($urandom_range(0, 31)), "R7");
        end
        step(0, 1, 64'd0, 64'd0, 5'h00, "R2");
        step(0, 1, 64'd0, 64'd0, 5'h00, "R2");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule